// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper Controller

This block is the digital controller for a single H-bridge that holds the peak load current near a set limit. When the bridge is driven, one high-side and the diagonally opposite low-side switch conduct. When the synchronized over-current comparator reports that the trip level has been reached, only the high-side switch is released. The low-side switch keeps conducting, so the current circulates through it and decays slowly. After a fixed number of cycles the high-side switch closes again and the cycle repeats.

Every switching event opens a blanking window. Those events are the end of the off period, a completed direction change, and a re-enable. During the window the comparator is not looked at. Because the window always follows a trip, the bridge always gets a minimum on-pulse, even when the current is already above target.

A change on the direction input first turns all four switches off for a dead-time window. It then enters blanking with the new diagonal selected. A separate output selects either the full reference level or a reduced level of about two thirds for an external reference divider. All control pins are plain level signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `chop_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four driver outputs and `ref_sel_o` are low.
- R2: In the on phase, direction high drives `src_a_o` and `snk_b_o`, and direction low drives `src_b_o` and `snk_a_o`. An accepted trip clears the active source output at the next clock edge.
- R3: After an accepted trip, the source output stays low for exactly OFF_CYC cycles while the active sink output stays high. The blanking window follows.
- R4: `trip_i` passes through a two-flop synchronizer. A trip that is high at rising edge k and accepted in the on phase drops the source output at edge k+2.
- R5: The blanking window lasts exactly BLANK_CYC cycles with the active source and sink both high. A trip seen during the window is discarded and is not held as pending.
- R6: When `dir_i` differs from the direction in use while the bridge is enabled and active, all four outputs go low at the next edge for exactly XOVER_CYC cycles, and the blanking window follows with the new diagonal. This cancels any off or blanking timer.
- R7: A low on `en_i` turns all four outputs off at the next edge and overrides every other event. On re-enable, the blanking window comes before any trip is honoured.
- R8: The source and sink outputs of the same leg (A or B) are never high in the same cycle.
- R9: `ref_sel_o` follows `full_n_i` one cycle later. Low selects the full reference level and high selects the reduced level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Bridge enable; low turns all drivers off |
| dir_i | input | 1 | Direction: high selects source A and sink B |
| full_n_i | input | 1 | Reference select request: low full, high reduced |
| trip_i | input | 1 | Over-current comparator flag, asynchronous |
| src_a_o | output | 1 | High-side driver enable, leg A |
| src_b_o | output | 1 | High-side driver enable, leg B |
| snk_a_o | output | 1 | Low-side driver enable, leg A |
| snk_b_o | output | 1 | Low-side driver enable, leg B |
| ref_sel_o | output | 1 | Reference select to the external divider |

## Verification
A direction change can land in the same cycle as an accepted trip, as the expiry of the off or blanking timer, or as a falling enable. Priority is disable first, then direction change, then timers and trips. The bench provokes these collisions with directed sequences: it flips `dir_i` on the exact cycle that the synchronized trip arrives, and again on the last cycle of the off period. Random traffic then mixes frequent trips with occasional direction and enable changes. Each cycle is judged against an independent cycle model of the requirements, which predicts all four driver outputs, so a wrong priority shows up as a mismatch in the dead-time or driver pattern.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XOVER = 3'd1,
    ST_BLANK = 3'd2,
    ST_ON    = 3'd3,
    ST_OFF   = 3'd4
  } state_t;

  typedef struct packed {
    logic src_a;
    logic src_b;
    logic snk_a;
    logic snk_b;
  } drv_t;
endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[i] <= 1'b0;
          else        pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 40,
  parameter int BLANK_CYC = 8,
  parameter int XOVER_CYC = 4,
  parameter int CW        = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          dir_i,
  input  logic          trip_s_i,
  input  logic          done_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output state_t        st_o,
  output logic          dir_o
);
  localparam logic [CW-1:0] OFF_LD   = CW'(OFF_CYC - 1);
  localparam logic [CW-1:0] BLANK_LD = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] XOVER_LD = CW'(XOVER_CYC - 1);

  state_t st_q, st_d;
  logic   dir_q, dir_d;

  always_comb begin
    st_d       = st_q;
    dir_d      = dir_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_IDLE) begin
      st_d       = ST_BLANK;
      dir_d      = dir_i;
      load_o     = 1'b1;
      load_val_o = BLANK_LD;
    end else if (dir_i != dir_q) begin
      st_d       = ST_XOVER;
      dir_d      = dir_i;
      load_o     = 1'b1;
      load_val_o = XOVER_LD;
    end else begin
      unique case (st_q)
        ST_XOVER: if (done_i) begin
          st_d       = ST_BLANK;
          load_o     = 1'b1;
          load_val_o = BLANK_LD;
        end
        ST_BLANK: if (done_i) st_d = ST_ON;
        ST_ON: if (trip_s_i) begin
          st_d       = ST_OFF;
          load_o     = 1'b1;
          load_val_o = OFF_LD;
        end
        ST_OFF: if (done_i) begin
          st_d       = ST_BLANK;
          load_o     = 1'b1;
          load_val_o = BLANK_LD;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
    end
  end

  assign st_o  = st_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/chop_drive.sv
module chop_drive
  import chop_pkg::*;
(
  input  state_t st_i,
  input  logic   dir_i,
  output drv_t   drv_o
);
  logic src_on, snk_on;

  always_comb begin
    src_on = (st_i == ST_BLANK) || (st_i == ST_ON);
    snk_on = src_on || (st_i == ST_OFF);
    drv_o.src_a = src_on &  dir_i;
    drv_o.src_b = src_on & ~dir_i;
    drv_o.snk_a = snk_on & ~dir_i;
    drv_o.snk_b = snk_on &  dir_i;
  end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int OFF_CYC     = 40,
  parameter int BLANK_CYC   = 8,
  parameter int XOVER_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dir_i,
  input  logic full_n_i,
  input  logic trip_i,
  output logic src_a_o,
  output logic src_b_o,
  output logic snk_a_o,
  output logic snk_b_o,
  output logic ref_sel_o
);
  localparam int MAXC = (OFF_CYC > BLANK_CYC)
                        ? ((OFF_CYC > XOVER_CYC) ? OFF_CYC : XOVER_CYC)
                        : ((BLANK_CYC > XOVER_CYC) ? BLANK_CYC : XOVER_CYC);
  localparam int CW = $clog2(MAXC + 1);

  logic          trip_s, done, load;
  logic [CW-1:0] load_val;
  state_t        st_q;
  logic          dir_q;
  drv_t          drv;
  logic          ref_q;

  chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(trip_i), .q_o(trip_s)
  );

  chop_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val), .done_o(done)
  );

  chop_fsm #(
    .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .XOVER_CYC(XOVER_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .dir_i(dir_i), .trip_s_i(trip_s),
    .done_i(done), .load_o(load), .load_val_o(load_val), .st_o(st_q), .dir_o(dir_q)
  );

  chop_drive u_drive (.st_i(st_q), .dir_i(dir_q), .drv_o(drv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= full_n_i;
  end

  assign src_a_o   = drv.src_a;
  assign src_b_o   = drv.src_b;
  assign snk_a_o   = drv.snk_a;
  assign snk_b_o   = drv.snk_b;
  assign ref_sel_o = ref_q;
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk
  import chop_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   en_i,
  input logic   dir_i,
  input logic   full_n_i,
  input logic   src_a_o,
  input logic   src_b_o,
  input logic   snk_a_o,
  input logic   snk_b_o,
  input logic   ref_sel_o,
  input state_t st,
  input logic   dir_q
);
  assert_leg_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_a_o && snk_a_o) && !(src_b_o && snk_b_o));

  assert_disable_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !src_a_o && !src_b_o && !snk_a_o && !snk_b_o);

  assert_xover_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && st != ST_IDLE && dir_i != dir_q)
      |=> !src_a_o && !src_b_o && !snk_a_o && !snk_b_o);

  assert_ref_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ref_sel_o == $past(full_n_i));

  assert_off_slow_decay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_OFF |-> !src_a_o && !src_b_o && $countones({snk_a_o, snk_b_o}) == 1);

  assert_blank_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_BLANK |-> $countones({src_a_o, src_b_o, snk_a_o, snk_b_o}) == 2);

  assert_one_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({src_a_o, src_b_o}));
endmodule

bind chop_ctrl chop_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .dir_i(dir_i), .full_n_i(full_n_i),
  .src_a_o(src_a_o), .src_b_o(src_b_o), .snk_a_o(snk_a_o), .snk_b_o(snk_b_o),
  .ref_sel_o(ref_sel_o), .st(st_q), .dir_q(dir_q)
);

// File: tb/tb_chop_ctrl.sv
module tb_chop_ctrl;
  localparam int CLK_PER = 10;
  localparam int P_OFF   = 7;
  localparam int P_BLANK = 3;
  localparam int P_XOVER = 2;

  localparam int M_IDLE = 0, M_XOVER = 1, M_BLANK = 2, M_ON = 3, M_OFF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dir = 1'b0, full_n = 1'b0, trip = 1'b0;
  logic src_a, src_b, snk_a, snk_b, ref_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  chop_ctrl #(.OFF_CYC(P_OFF), .BLANK_CYC(P_BLANK), .XOVER_CYC(P_XOVER)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .dir_i(dir), .full_n_i(full_n),
    .trip_i(trip), .src_a_o(src_a), .src_b_o(src_b), .snk_a_o(snk_a),
    .snk_b_o(snk_b), .ref_sel_o(ref_sel)
  );

  // Reference cycle model built from the requirements.
  int   m_st, m_left;
  logic m_dir, m_s1, m_s2, m_ref;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= M_IDLE; m_left <= 0; m_dir <= 1'b0;
      m_s1 <= 1'b0; m_s2 <= 1'b0; m_ref <= 1'b0;
    end else begin
      m_s1  <= trip;
      m_s2  <= m_s1;
      m_ref <= full_n;
      if (!en) begin
        m_st <= M_IDLE;
      end else if (m_st == M_IDLE) begin
        m_st <= M_BLANK; m_left <= P_BLANK; m_dir <= dir;
      end else if (dir != m_dir) begin
        m_st <= M_XOVER; m_left <= P_XOVER; m_dir <= dir;
      end else begin
        case (m_st)
          M_XOVER: if (m_left <= 1) begin m_st <= M_BLANK; m_left <= P_BLANK; end
                   else m_left <= m_left - 1;
          M_BLANK: if (m_left <= 1) m_st <= M_ON; else m_left <= m_left - 1;
          M_ON:    if (m_s2) begin m_st <= M_OFF; m_left <= P_OFF; end
          M_OFF:   if (m_left <= 1) begin m_st <= M_BLANK; m_left <= P_BLANK; end
                   else m_left <= m_left - 1;
          default: m_st <= M_IDLE;
        endcase
      end
    end
  end

  function automatic logic [3:0] exp_drv(int st, logic d);
    case (st)
      M_BLANK, M_ON: return d ? 4'b1001 : 4'b0110;
      M_OFF:         return d ? 4'b0001 : 4'b0010;
      default:       return 4'b0000;
    endcase
  endfunction

  function automatic string tag_of(int st);
    case (st)
      M_IDLE:  return "R7";
      M_XOVER: return "R6";
      M_BLANK: return "R5";
      M_ON:    return "R2";
      default: return "R3 R4";
    endcase
  endfunction

  task automatic compare();
    logic [3:0] act, exp;
    act = {src_a, src_b, snk_a, snk_b};
    exp = exp_drv(m_st, m_dir);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s drivers act=%b exp=%b t=%0t", tag_of(m_st), act, exp, $time);
    end
    checks++;
    if (ref_sel !== m_ref) begin
      errors++;
      $display("FAIL R9 ref_sel act=%b exp=%b", ref_sel, m_ref);
    end
    checks++;
    if ((src_a && snk_a) || (src_b && snk_b)) begin
      errors++;
      $display("FAIL R8 leg act=%b exp=no same-leg pair", act);
    end
  endtask

  // Check at the falling edge, then drive the inputs for the next rising edge.
  task automatic cyc(input logic e, input logic d, input logic t, input logic f);
    @(negedge clk);
    compare();
    en = e; dir = d; trip = t; full_n = f;
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    #(CLK_PER * 3);
    // R1: reset state
    checks++;
    if ({src_a, src_b, snk_a, snk_b, ref_sel} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset act=%b exp=00000", {src_a, src_b, snk_a, snk_b, ref_sel});
    end
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);   // R1: first cycle after reset
    // R7 enable then R5 blanking, trip during blanking is discarded
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    // R2 R4: single trip pulse, R3 off period
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 14; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1);
    // minimum duty: trip held high
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0);
    // R6: direction change during off period
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    // collision: direction flips on the cycle the synchronized trip arrives
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    // collision: disable and direction change together, then disable in crossover
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 1'b0, 1'b0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic ne, nd, nt, nf;
      ne = ($urandom_range(0, 79) != 0) ? 1'b1 : 1'b0;
      nd = ($urandom_range(0, 39) == 0) ? ~dir : dir;
      nt = ($urandom_range(0, 9) < 3) ? 1'b1 : 1'b0;
      nf = ($urandom_range(0, 19) == 0) ? ~full_n : full_n;
      cyc(ne, nd, nt, nf);
    end
    cyc(1'b1, dir, 1'b0, full_n);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule